// File: doc/BRIEF.md
# No-turnaround pipelined synchronous SRAM

This block is a synthesizable behavioural model of a pipelined synchronous SRAM whose bus never needs an idle cycle between a read and a write. A small array of 256 words is split into four 9-bit byte lanes. On every enabled rising clock edge the block registers one address cycle: an address, three chip enables, a load/advance strobe, a read/write select and four active-low byte enables. A cycle either loads a new external address or advances a 2-bit burst counter. The burst order is linear or interleaved.

Reads and writes keep the same spacing on the bus. Read data comes out of a registered output stage. Write data for an address cycle is taken two enabled edges after that cycle. A controller can therefore issue read, write, read on back-to-back cycles without any dead bus cycle. The data bus is given as an input, an output and a drive enable, and the drive enable is gated by an asynchronous output enable. A clock enable freezes the whole pipeline. A snooze input freezes it as well and releases the bus.

Top module: `pipe_sram`

## Requirements
- R1: For a read address cycle captured at enabled edge k, the output register is loaded at enabled edge k+1. From then until the next enabled edge, `dq_t`=1 (provided `oe_n`=0 and `snooze`=0) and `dq_o` carries the word, so a controller captures it at edge k+2.
- R2: For a write address cycle captured at enabled edge k, `dq_i` is sampled at enabled edge k+2. A read returns every write whose address cycle came before it, and `dq_t`=0 while the bus belongs to a write or to an idle cycle.
- R3: The device is selected only when a load cycle (`load_n`=0) sees `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A load cycle with any enable false is a deselect. That cycle and all advance cycles after it leave memory unchanged and keep `dq_t`=0.
- R4: In an advance cycle (`load_n`=1) the chip enables and `we_n` are ignored. The cycle repeats the operation, read or write, of the last load cycle.
- R5: For a load address A, the four accesses of a burst use A[7:2] with low bits s^n when `ilv_mode`=1, and (s+n) mod 4 when `ilv_mode`=0. Here s=A[1:0] and n=0,1,2,3, and the sequence wraps to n=0 after n=3.
- R6: Lane l occupies bits [9l+8:9l] of the data bus. In a write cycle lane l is written only if `be_n[l]`=0, where the enables are taken from the address cycle. With `be_n`=4'b1111 the write is aborted and memory is unchanged.
- R7: A read whose output window has `oe_n`=1 is a dummy read. It gives `dq_t`=0 and has no other effect.
- R8: An edge with `cken_n`=1 is ignored. The burst state, both pipeline stages and the output register hold, and write data is taken at the next enabled edge.
- R9: While `snooze`=1 all other inputs are ignored at the clock edge, `dq_t`=0, and memory contents and pipeline state are kept.
- R10: A read whose output register loads at the same edge where an older write's data is sampled for the same address returns that new data. The merge is byte by byte with the write's enables, and unwritten lanes keep the old contents.
- R11: After reset `dq_t`=0 and the burst state is deselected, so advance cycles before the first load drive nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snooze | input | 1 | High: freeze and release the bus |
| cken_n | input | 1 | Active-low clock enable |
| load_n | input | 1 | Low: load address; high: advance burst |
| ce1_n | input | 1 | Active-low chip enable |
| ce2 | input | 1 | Active-high chip enable |
| ce3_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Low: write, high: read (load cycles only) |
| be_n | input | 4 | Active-low byte lane enables |
| addr | input | 8 | Word address |
| ilv_mode | input | 1 | 1: interleaved burst, 0: linear burst |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_i | input | 36 | Write data from the bus |
| dq_o | output | 36 | Read data to the bus |
| dq_t | output | 1 | Bus drive enable (1 = driven) |

## Verification
The output register loads a read result at the same edge where an older write's data is sampled from the bus. When both target the same word, the newly arriving bytes must be merged into the result. The bench provokes this with a write followed at once by a read of the same word, using partial byte enables, in a directed run and again inside the random stream. Each result is judged against a reference array that the bench updates in the cycle it places the write data on the bus.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low address bits of burst access number cnt starting at start.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       ilv);
    logic [1:0] res;
    if (ilv) res = start ^ cnt;
    else     res = start + cnt;
    return res;
  endfunction

endpackage

// File: rtl/pipe_sram_seq.sv
module pipe_sram_seq
  import pipe_sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          load_n,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          ce3_n,
  input  logic          we_n,
  input  logic          ilv_mode,
  input  logic [AW-1:0] addr,
  output op_e           cyc_op,
  output logic [AW-1:0] cyc_addr
);

  op_e           op_q, op_d;
  logic [AW-1:0] base_q, base_d;
  logic [1:0]    cnt_q, cnt_d;
  logic          sel;

  always_comb begin
    sel = ~ce1_n & ce2 & ~ce3_n;
    if (!load_n) begin
      op_d     = sel ? (we_n ? OP_READ : OP_WRITE) : OP_NONE;
      base_d   = addr;
      cnt_d    = 2'd0;
      cyc_addr = addr;
    end else begin
      op_d     = op_q;
      base_d   = base_q;
      cnt_d    = cnt_q + 2'd1;
      cyc_addr = {base_q[AW-1:2], burst_low(base_q[1:0], cnt_d, ilv_mode)};
    end
    cyc_op = op_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (step_en) begin
      op_q   <= op_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/pipe_sram_array.sv
module pipe_sram_array #(
  parameter int AW = 8,
  parameter int NL = 4,
  parameter int LW = 9,
  localparam int DW    = NL * LW,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [NL-1:0] wr_lane,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [LW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_lane[l]) cells[wr_addr] <= wr_data[l*LW +: LW];
    end

    assign rd_data[l*LW +: LW] = cells[rd_addr];
  end

endmodule

// File: rtl/pipe_sram_pipe.sv
module pipe_sram_pipe
  import pipe_sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int NL = 4,
  parameter int LW = 9,
  localparam int DW = NL * LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  op_e           cyc_op,
  input  logic [AW-1:0] cyc_addr,
  input  logic [NL-1:0] be_n,
  input  logic [DW-1:0] dq_i,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [NL-1:0] wr_lane,
  output logic [DW-1:0] wr_data,
  output op_e           s1_op,
  output logic [AW-1:0] s1_addr,
  output logic [DW-1:0] q_data,
  output logic          q_vld
);

  op_e           s1_op_q, s2_op_q;
  logic [AW-1:0] s1_addr_q, s2_addr_q;
  logic [NL-1:0] s1_be_q, s2_be_q;
  logic [DW-1:0] q_data_q, q_data_d;
  logic          q_vld_q, q_vld_d;
  logic          hit;
  logic [DW-1:0] fwd_data;

  // Stage 2 write whose data is on dq_i now, same word as the read in stage 1.
  assign hit = (s2_op_q == OP_WRITE) && (s2_addr_q == s1_addr_q);

  for (genvar l = 0; l < NL; l++) begin : g_fwd
    assign fwd_data[l*LW +: LW] = (hit && !s2_be_q[l]) ? dq_i[l*LW +: LW]
                                                        : rd_data[l*LW +: LW];
  end

  assign rd_addr = s1_addr_q;
  assign wr_en   = step_en && (s2_op_q == OP_WRITE);
  assign wr_addr = s2_addr_q;
  assign wr_lane = ~s2_be_q;
  assign wr_data = dq_i;

  always_comb begin
    q_vld_d  = (s1_op_q == OP_READ);
    q_data_d = q_vld_d ? fwd_data : q_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op_q   <= OP_NONE;
      s1_addr_q <= '0;
      s1_be_q   <= '1;
      s2_op_q   <= OP_NONE;
      s2_addr_q <= '0;
      s2_be_q   <= '1;
      q_data_q  <= '0;
      q_vld_q   <= 1'b0;
    end else if (step_en) begin
      s1_op_q   <= cyc_op;
      s1_addr_q <= cyc_addr;
      s1_be_q   <= be_n;
      s2_op_q   <= s1_op_q;
      s2_addr_q <= s1_addr_q;
      s2_be_q   <= s1_be_q;
      q_data_q  <= q_data_d;
      q_vld_q   <= q_vld_d;
    end
  end

  assign s1_op   = s1_op_q;
  assign s1_addr = s1_addr_q;
  assign q_data  = q_data_q;
  assign q_vld   = q_vld_q;

endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int NL = 4,
  parameter int LW = 9,
  localparam int DW = NL * LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snooze,
  input  logic          cken_n,
  input  logic          load_n,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          ce3_n,
  input  logic          we_n,
  input  logic [NL-1:0] be_n,
  input  logic [AW-1:0] addr,
  input  logic          ilv_mode,
  input  logic          oe_n,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_t
);

  logic          step_en;
  op_e           cyc_op;
  logic [AW-1:0] cyc_addr;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [NL-1:0] wr_lane;
  logic [DW-1:0] wr_data;
  op_e           s1_op;
  logic [AW-1:0] s1_addr;
  logic [DW-1:0] q_data;
  logic          q_vld;

  assign step_en = ~cken_n & ~snooze;

  pipe_sram_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (step_en),
    .load_n   (load_n),
    .ce1_n    (ce1_n),
    .ce2      (ce2),
    .ce3_n    (ce3_n),
    .we_n     (we_n),
    .ilv_mode (ilv_mode),
    .addr     (addr),
    .cyc_op   (cyc_op),
    .cyc_addr (cyc_addr)
  );

  pipe_sram_pipe #(.AW(AW), .NL(NL), .LW(LW)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (step_en),
    .cyc_op   (cyc_op),
    .cyc_addr (cyc_addr),
    .be_n     (be_n),
    .dq_i     (dq_i),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_lane  (wr_lane),
    .wr_data  (wr_data),
    .s1_op    (s1_op),
    .s1_addr  (s1_addr),
    .q_data   (q_data),
    .q_vld    (q_vld)
  );

  pipe_sram_array #(.AW(AW), .NL(NL), .LW(LW)) u_array (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_lane (wr_lane),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign dq_o = q_data;
  assign dq_t = q_vld & ~oe_n & ~snooze;

endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk
  import pipe_sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step_en,
  input logic          snooze,
  input logic          load_n,
  input logic          ce1_n,
  input logic          ce2,
  input logic          ce3_n,
  input op_e           s1_op,
  input logic [AW-1:0] s1_addr,
  input logic [DW-1:0] q_data,
  input logic          q_vld
);

  AST_READ_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && s1_op == OP_READ) |=> q_vld); // R1

  AST_DESEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_n && !(!ce1_n && ce2 && !ce3_n)) |=> (s1_op == OP_NONE)); // R3

  AST_ADV_KEEP_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && load_n) |=> (s1_op == $past(s1_op))); // R4

  AST_BURST_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && load_n) |=> (s1_addr[AW-1:2] == $past(s1_addr[AW-1:2]))); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> ($stable(q_data) && $stable(q_vld) && $stable(s1_addr))); // R8

  AST_SNOOZE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    snooze |=> ($stable(s1_op) && $stable(q_data))); // R9

endmodule

bind pipe_sram pipe_sram_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .step_en (step_en),
  .snooze  (snooze),
  .load_n  (load_n),
  .ce1_n   (ce1_n),
  .ce2     (ce2),
  .ce3_n   (ce3_n),
  .s1_op   (s1_op),
  .s1_addr (s1_addr),
  .q_data  (q_data),
  .q_vld   (q_vld)
);

// File: tb/test_pipe_sram.sv
module test_pipe_sram;

  localparam int AW = 8;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          snooze, cken_n, load_n, ce1_n, ce2, ce3_n, we_n;
  logic [NL-1:0] be_n;
  logic [AW-1:0] addr;
  logic          ilv_mode, oe_n;
  logic [DW-1:0] dq_i, dq_o;
  logic          dq_t;

  pipe_sram #(.AW(AW), .NL(NL), .LW(LW)) i_pipe_sram (
    .clk(clk), .rst_n(rst_n), .snooze(snooze), .cken_n(cken_n),
    .load_n(load_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n),
    .be_n(be_n), .addr(addr), .ilv_mode(ilv_mode), .oe_n(oe_n),
    .dq_i(dq_i), .dq_o(dq_o), .dq_t(dq_t)
  );

  always #2 clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  string tag = "R11";

  logic [DW-1:0] ref_mem [1 << AW];

  // Bench burst model: 0 none, 1 read, 2 write
  int            m_op = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  int            s1_op_m = 0, own_op = 0;
  logic [AW-1:0] s1_addr_m = '0, own_addr = '0;
  logic [NL-1:0] s1_be_m = '1, own_be = '1;
  logic [DW-1:0] own_exp = '0;

  function automatic logic [1:0] order_bits(logic [1:0] s, logic [1:0] n, logic ilv);
    int v;
    if (ilv) v = int'(s ^ n);
    else     v = (int'(s) + int'(n)) % 4;
    return v[1:0];
  endfunction

  function automatic logic [DW-1:0] rnd_word();
    return {$urandom(), $urandom()};
  endfunction

  task automatic chk(input string t, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic step(input logic ld, input logic sok, input logic we,
                      input logic [AW-1:0] a, input logic [NL-1:0] be,
                      input logic oe, input logic ck, input logic zz,
                      input logic ilv);
    logic          was_en, sel, exp_t;
    logic [AW-1:0] ca;
    logic [DW-1:0] d;
    string         tt;
    int            k;
    @(negedge clk);
    was_en = !cken_n && !snooze;
    if (was_en) begin
      own_op = s1_op_m; own_addr = s1_addr_m; own_be = s1_be_m;
      if (own_op == 1) own_exp = ref_mem[own_addr];
      sel = !ce1_n && ce2 && !ce3_n;
      if (!load_n) begin
        m_op = sel ? (we_n ? 1 : 2) : 0;
        m_base = addr; m_cnt = 2'd0; ca = addr;
      end else begin
        m_cnt = m_cnt + 2'd1;
        ca = {m_base[AW-1:2], order_bits(m_base[1:0], m_cnt, ilv_mode)};
      end
      s1_op_m = m_op; s1_addr_m = ca; s1_be_m = be_n;
      d = rnd_word();
      dq_i = d;
      if (own_op == 2)
        for (int l = 0; l < NL; l++)
          if (!own_be[l]) ref_mem[own_addr][l*LW +: LW] = d[l*LW +: LW];
    end
    load_n = ld; we_n = we; addr = a; be_n = be; oe_n = oe;
    cken_n = ck; snooze = zz; ilv_mode = ilv;
    if (sok) begin
      ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    end else begin
      k = $urandom_range(2);
      ce1_n = (k == 0); ce2 = (k != 1); ce3_n = (k == 2);
    end
    #1;
    exp_t = (own_op == 1) && !oe_n && !snooze;
    tt = snooze ? "R9" : ((own_op == 1 && oe_n) ? "R7" : tag);
    chk(tt, {{(DW-1){1'b0}}, dq_t}, {{(DW-1){1'b0}}, exp_t});
    if (exp_t) chk(tag, dq_o, own_exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b1, '0, '1, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic burst(input logic we, input logic [AW-1:0] a, input logic ilv,
                       input logic [NL-1:0] be);
    step(1'b0, 1'b1, we, a, be, 1'b0, 1'b0, 1'b0, ilv);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, ~we, ~a, be, 1'b0, 1'b0, 1'b0, ilv);
  endtask

  task automatic single(input logic we, input logic [AW-1:0] a, input logic [NL-1:0] be);
    step(1'b0, 1'b1, we, a, be, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    logic [AW-1:0] x;
    void'($urandom(32'd4711));
    rst_n = 1'b0; snooze = 1'b0; cken_n = 1'b0; load_n = 1'b1;
    ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1; we_n = 1'b1; be_n = '1;
    addr = '0; ilv_mode = 1'b0; oe_n = 1'b0; dq_i = '0;
    for (int i = 0; i < 1 << AW; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    tag = "R11";
    chk(tag, {{(DW-1){1'b0}}, dq_t}, '0);
    rst_n = 1'b1;
    // Advance cycles straight after reset: nothing selected
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0);

    // Fill with write bursts; we_n=1 on advances must be ignored
    tag = "R4";
    for (int b = 0; b < (1 << AW); b += 4) burst(1'b0, AW'(b), 1'b0, '0);

    // Read back everything
    tag = "R2";
    for (int b = 0; b < (1 << AW); b += 4) burst(1'b1, AW'(b), 1'b0, '1);

    // Burst orders from non-zero starts, mixed with writes
    tag = "R5";
    for (int i = 0; i < 24; i++) begin
      x = AW'($urandom());
      burst(i % 3 == 0 ? 1'b0 : 1'b1, x, i[0], NL'($urandom()));
      burst(1'b1, x, ~i[0], '1);
    end

    // Deselects, then advances with we_n=0; memory must not change
    tag = "R3";
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 1'b0, 1'b0, AW'($urandom()), '0, 1'b0, 1'b0, 1'b0, 1'b0);
      for (int j = 0; j < 3; j++) step(1'b1, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    end
    for (int b = 0; b < 64; b += 4) burst(1'b1, AW'(b), 1'b1, '1);

    // Byte lanes and aborts
    tag = "R6";
    for (int i = 0; i < 16; i++) begin
      x = AW'($urandom());
      single(1'b0, x, ~(NL'(1) << (i % NL)));
      single(1'b0, x + 1, '1);
      idle(1);
      single(1'b1, x, '1);
      single(1'b1, x + 1, '1);
    end

    // Read-write-read back to back on one word, forwarding at the data edge
    tag = "R10";
    for (int i = 0; i < 24; i++) begin
      x = AW'($urandom());
      single(1'b1, x, '1);
      single(1'b0, x, NL'($urandom()));
      single(1'b1, x, '1);
      single(1'b0, x, '0);
      single(1'b1, x, '1);
    end

    // Stalls inside bursts, garbage on the inputs while stalled
    tag = "R8";
    for (int i = 0; i < 12; i++) begin
      x = AW'($urandom());
      step(1'b0, 1'b1, i[0], x, NL'($urandom()), 1'b0, 1'b0, 1'b0, i[1]);
      step(1'b1, 1'b0, 1'b1, x, NL'($urandom()), 1'b0, 1'b0, 1'b0, i[1]);
      for (int j = 0; j < 3; j++)
        step(1'(j % 2), 1'b0, 1'($urandom()), AW'($urandom()), NL'($urandom()),
             1'b0, 1'b1, 1'b0, i[1]);
      step(1'b1, 1'b0, 1'b1, x, NL'($urandom()), 1'b0, 1'b0, 1'b0, i[1]);
      step(1'b1, 1'b0, 1'b1, x, NL'($urandom()), 1'b0, 1'b0, 1'b0, i[1]);
      burst(1'b1, x, i[1], '1);
    end

    // Dummy reads
    tag = "R7";
    for (int i = 0; i < 6; i++) begin
      x = AW'($urandom());
      step(1'b0, 1'b1, 1'b1, x, '1, 1'b1, 1'b0, 1'b0, 1'b0);
      for (int j = 0; j < 4; j++) step(1'b1, 1'b0, 1'b1, x, '1, 1'b1, 1'b0, 1'b0, 1'b0);
    end

    // Snooze in mid-burst
    tag = "R9";
    for (int i = 0; i < 8; i++) begin
      x = AW'($urandom());
      step(1'b0, 1'b1, i[0], x, '0, 1'b0, 1'b0, 1'b0, 1'b1);
      for (int j = 0; j < 3; j++)
        step(1'($urandom()), 1'b1, 1'b0, AW'($urandom()), '0, 1'b0, 1'b0, 1'b1, 1'b1);
      for (int j = 0; j < 3; j++) step(1'b1, 1'b0, 1'b1, x, '0, 1'b0, 1'b0, 1'b0, 1'b1);
      burst(1'b1, x, 1'b1, '1);
    end

    // Constrained random mix
    tag = "R1";
    for (int i = 0; i < 3000; i++) begin
      logic [NL-1:0] be;
      be = ($urandom_range(7) == 0) ? '1 : NL'($urandom());
      step($urandom_range(2) != 0, $urandom_range(9) != 0, 1'($urandom()),
           AW'($urandom_range(15)), be, $urandom_range(9) == 0,
           $urandom_range(9) == 0, $urandom_range(29) == 0, 1'($urandom()));
    end
    idle(4);
    finish_run();
  end

endmodule